// File: doc/BRIEF.md
# Bus-Master Disk DMA Control Registers

This block holds the host-visible control state for bus-master DMA on a number of disk channels. The default is two. Each channel owns an 8-byte slice of one I/O window. The slice holds a command byte, a status byte, two unimplemented bytes and a 32-bit pointer to the channel's descriptor table. The host reaches the window with byte, halfword or dword accesses. Reads are combinational.

Each channel drives a single-cycle launch pulse and a single-cycle abort pulse toward a separate DMA engine. It also gives that engine the transfer direction and the table pointer. The engine reports back per channel: completion raises the interrupt flag and a fault raises the error flag. Both drop the active flag.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, every command, status and pointer register reads zero, and no launch or abort pulse is driven.
- R2: Channel c uses window offsets 8c to 8c+7. Within a slice, offset 0 is command, offset 2 is status and offsets 4–7 are the pointer, least significant byte at offset 4. A write to one channel leaves every other channel unchanged. A wider access to offsets 0–3 acts on each byte lane it covers.
- R3: Only command bit 0 (start) and bit 3 (direction) are stored, and the other command bits read 0. The direction output of a channel follows its stored bit 3.
- R4: A command write with bit 0 = 1 while status bit 0 (active) is clear sets the active flag. The launch output of that channel goes high for exactly the one cycle after the write.
- R5: A command write with bit 0 = 1 while the active flag is already set issues no launch pulse and leaves the active flag set.
- R6: A command write with bit 0 = 0 clears the active flag. The abort output goes high for exactly the one cycle after the write.
- R7: A status write loads bits 6:5 from the data and leaves bit 0 as it was. It clears bit 2 (interrupt) and bit 1 (error) where the data bit is 1. Status bits 7, 4 and 3 read 0.
- R8: An engine completion input sets status bit 2 and clears bit 0. An engine fault input sets status bit 1 and clears bit 0. An engine set wins over a host clear in the same cycle.
- R9: Pointer writes replace only the addressed byte lanes. A halfword at offset 7 reaches only byte 7. A dword write replaces all 32 bits whatever the low address bits are. Pointer bits 1:0 always stay 0, and the pointer output shows the new value from the cycle after the write.
- R10: A read returns the addressed 32-bit word shifted right by 8 × (offset mod 4), cut to 8 or 16 bits for byte and halfword reads. A dword read returns the full word.
- R11: Offsets 1 and 3 of every channel read 0xFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Byte offset in the window |
| host_size | input | 2 | 0 byte, 1 halfword, 2 dword |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rdata | output | 32 | Read data, right-aligned |
| eng_done | input | NCH | Per-channel completion from the engine |
| eng_fault | input | NCH | Per-channel fault from the engine |
| eng_start | output | NCH | One-cycle launch pulse |
| eng_cancel | output | NCH | One-cycle abort pulse |
| chan_dir | output | NCH | Stored direction bit |
| chan_ptr | output | 32·NCH | Descriptor-table pointers, channel 0 in the low bits |

## Verification
The hardest case to reach is a clash in one cycle between the engine and the host on the same status flag. An example is a completion that arrives while the host writes a one to clear that same interrupt bit. The bench drives the engine inputs itself. It raises completion at the same falling edge where it presents the status write, so both are sampled by one rising edge. It then checks that the flag survives. The bench also arms a second launch while a channel is still active. It checks that no pulse appears.

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int NCH = 2,
  localparam int AW = $clog2(NCH*8),
  localparam int CW = AW-3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [1:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic [NCH-1:0]    eng_done,
  input  logic [NCH-1:0]    eng_fault,
  output logic [NCH-1:0]    eng_start,
  output logic [NCH-1:0]    eng_cancel,
  output logic [NCH-1:0]    chan_dir,
  output logic [NCH*32-1:0] chan_ptr
);

  logic [1:0]  lane;
  logic [3:0]  be;
  logic [31:0] wal, word, sh;
  logic [CW-1:0] ch;
  logic ctl_wr, ptr_wr;

  logic [NCH-1:0] run, dir, act, err, irq, s5, s6;
  logic [NCH-1:0][31:0] ptr;

  assign lane   = (host_size == 2'd2) ? 2'd0 : host_addr[1:0];
  assign wal    = host_wdata << {lane, 3'b000};
  assign ch     = host_addr[AW-1:3];
  assign ctl_wr = host_sel && host_wr && !host_addr[2];
  assign ptr_wr = host_sel && host_wr &&  host_addr[2];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      case (host_size)
        2'd0:    be[k] = (k == int'(lane));
        2'd1:    be[k] = (k >= int'(lane)) && (k < int'(lane) + 2);
        default: be[k] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0; dir <= '0; act <= '0; err <= '0; irq <= '0;
      s5 <= '0; s6 <= '0; ptr <= '0;
      eng_start <= '0; eng_cancel <= '0;
    end else begin
      eng_start  <= '0;
      eng_cancel <= '0;
      for (int i = 0; i < NCH; i++) begin
        if (eng_done[i]) begin
          irq[i] <= 1'b1;
          act[i] <= 1'b0;
        end
        if (eng_fault[i]) begin
          err[i] <= 1'b1;
          act[i] <= 1'b0;
        end
        if (ctl_wr && ch == CW'(i)) begin
          if (be[2]) begin
            s6[i] <= wal[22];
            s5[i] <= wal[21];
            if (wal[18] && !eng_done[i])  irq[i] <= 1'b0;
            if (wal[17] && !eng_fault[i]) err[i] <= 1'b0;
          end
          if (be[0]) begin
            run[i] <= wal[0];
            dir[i] <= wal[3];
            if (!wal[0]) begin
              act[i]        <= 1'b0;
              eng_cancel[i] <= 1'b1;
            end else if (!act[i]) begin
              act[i]       <= 1'b1;
              eng_start[i] <= 1'b1;
            end
          end
        end
        if (ptr_wr && ch == CW'(i)) begin
          for (int k = 0; k < 4; k++)
            if (be[k])
              ptr[i][8*k +: 8] <= (k == 0) ? (wal[7:0] & 8'hFC) : wal[8*k +: 8];
        end
      end
    end
  end

  always_comb begin
    if (host_addr[2])
      word = ptr[ch];
    else
      word = {8'hFF, 1'b0, s6[ch], s5[ch], 2'b00, irq[ch], err[ch], act[ch],
              8'hFF, 4'b0000, dir[ch], 2'b00, run[ch]};
    sh = word >> {lane, 3'b000};
    case (host_size)
      2'd0:    host_rdata = {24'd0, sh[7:0]};
      2'd1:    host_rdata = {16'd0, sh[15:0]};
      default: host_rdata = sh;
    endcase
  end

  assign chan_dir = dir;
  assign chan_ptr = ptr;

endmodule

module bmdma_regs_chk #(
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [NCH-1:0]    eng_start,
  input logic [NCH-1:0]    eng_cancel,
  input logic [NCH*32-1:0] chan_ptr
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R4
    start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[i] |=> !eng_start[i]);
    // R4
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[i] |-> $past(host_sel && host_wr));
    // R6
    cancel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cancel[i] |-> $past(host_sel && host_wr));
    // R6
    start_cancel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(eng_start[i] && eng_cancel[i]));
    // R9
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_ptr[32*i +: 2] == 2'b00);
  end
endmodule

bind bmdma_regs bmdma_regs_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .eng_start(eng_start), .eng_cancel(eng_cancel), .chan_ptr(chan_ptr)
);

// File: tb/sim_bmdma_regs.sv
module sim_bmdma_regs;
  logic        clk = 0, rst_n = 0;
  logic        host_sel = 0, host_wr = 0;
  logic [3:0]  host_addr = 0;
  logic [1:0]  host_size = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [1:0]  eng_done = 0, eng_fault = 0, eng_start, eng_cancel, chan_dir;
  logic [63:0] chan_ptr;
  int checks = 0, fails = 0, wd = 0;
  bit done_flag = 0;

  bmdma_regs u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_size = s; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [1:0] s, logic [31:0] exp);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = a; host_size = s;
    #5 chk(tag, host_rdata, exp);
    host_sel = 0;
  endtask

  task automatic engine(logic [1:0] dn, logic [1:0] ft);
    @(negedge clk);
    eng_done = dn; eng_fault = ft;
    @(negedge clk);
    eng_done = 0; eng_fault = 0;
  endtask

  task automatic t_reset;
    rd("R1 cmd0", 0, 0, 0);
    rd("R1 stat0", 2, 0, 0);
    rd("R1 ptr0", 4, 2, 0);
    rd("R1 ptr1", 12, 2, 0);
    chk("R1 pulses", {30'd0, eng_start | eng_cancel}, 0);
  endtask

  task automatic t_start;
    wr(0, 0, 32'hFF);
    chk("R4 start pulse", {30'd0, eng_start}, 2'b01);
    @(negedge clk);
    chk("R4 pulse width", {30'd0, eng_start}, 0);
    rd("R3 cmd mask", 0, 0, 32'h09);
    chk("R3 dir out", {30'd0, chan_dir}, 2'b01);
    rd("R4 active", 2, 0, 32'h01);
  endtask

  task automatic t_restart;
    wr(0, 0, 32'h01);
    chk("R5 no pulse", {30'd0, eng_start}, 0);
    rd("R5 still active", 2, 0, 32'h01);
    rd("R3 dir cleared", 0, 0, 32'h01);
  endtask

  task automatic t_stop;
    wr(0, 0, 32'h00);
    chk("R6 cancel pulse", {30'd0, eng_cancel}, 2'b01);
    @(negedge clk);
    chk("R6 cancel width", {30'd0, eng_cancel}, 0);
    rd("R6 inactive", 2, 0, 0);
  endtask

  task automatic t_engine;
    wr(8, 0, 32'h01);
    chk("R2 ch1 start", {30'd0, eng_start}, 2'b10);
    engine(2'b10, 2'b00);
    rd("R8 done", 10, 0, 32'h04);
    wr(8, 0, 32'h01);
    engine(2'b00, 2'b10);
    rd("R8 fault", 10, 0, 32'h06);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 10; host_size = 0; host_wdata = 32'h04;
    eng_done = 2'b10;
    @(negedge clk);
    host_sel = 0; host_wr = 0; eng_done = 0;
    rd("R8 set wins", 10, 0, 32'h06);
    wr(10, 0, 32'h06);
    rd("R7 w1c both", 10, 0, 0);
    rd("R2 ch0 untouched", 2, 0, 0);
  endtask

  task automatic t_status;
    engine(2'b01, 2'b01);
    wr(0, 0, 32'h01);
    rd("R7 setup", 2, 0, 32'h07);
    wr(2, 0, 32'hFB);
    rd("R7 rw and w1c", 2, 0, 32'h65);
    wr(2, 0, 32'h04);
    rd("R7 bit0 kept", 2, 0, 32'h01);
    wr(0, 0, 32'h00);
  endtask

  task automatic t_pointer;
    wr(4, 2, 32'h12345677);
    rd("R9 dword align", 4, 2, 32'h12345674);
    wr(6, 0, 32'hAB);
    rd("R9 byte lane", 4, 2, 32'h12AB5674);
    wr(5, 1, 32'hCDEF);
    rd("R9 half lane", 4, 2, 32'h12CDEF74);
    wr(4, 0, 32'hFF);
    rd("R9 low bits", 4, 2, 32'h12CDEFFC);
    wr(7, 1, 32'hBEEF);
    rd("R9 half at 7", 4, 2, 32'hEFCDEFFC);
    chk("R9 ptr out", chan_ptr[31:0], 32'hEFCDEFFC);
    rd("R10 byte rd", 5, 0, 32'hEF);
    rd("R10 half rd", 6, 1, 32'hEFCD);
    rd("R10 half rd 7", 7, 1, 32'h00EF);
    wr(6, 2, 32'h00000103);
    rd("R9 dword ignores offset", 4, 2, 32'h00000100);
    rd("R2 ch1 ptr isolated", 12, 2, 0);
    chk("R2 ch1 ptr out", chan_ptr[63:32], 0);
  endtask

  task automatic t_holes;
    wr(1, 0, 32'h55);
    wr(11, 0, 32'h55);
    rd("R11 off1", 1, 0, 32'hFF);
    rd("R11 off11", 11, 0, 32'hFF);
    rd("R10 ctl dword", 0, 2, 32'hFF00FF00);
    wr(10, 1, 32'h5560);
    rd("R2 wide ctl write", 10, 1, 32'hFF60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_start;
    t_restart;
    t_stop;
    t_engine;
    t_status;
    t_pointer;
    t_holes;
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", wd, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule